// File: doc/BRIEF.md
# Power-on Boot Sequencer with NVM-to-RAM Code Load

This block brings a flash-less microcontroller out of power-on reset. The power-on reset is its only hardware reset. On first power-up, and again each time the chip wakes from a low-power shutdown, it holds the CPU halted. While the CPU is halted, the block holds the port output latches at all ones in open-drain mode, keeps the peripherals (interrupts, timers, special registers) in reset, and selects the internal oscillator as the system clock. It then waits for a fixed settling time and copies user code one word at a time from a one-time-programmable memory read port into the code RAM write port. After the copy it releases the CPU, which starts fetching at address zero.

Wake from shutdown comes from any GPIO input pulled low, after a two-flop synchronizer. A sleep-timer expiry also wakes the chip, but only if the timer was enabled when shutdown was entered. Shutdown is entered from the running state by a one-cycle strobe. A debug mode uses a shorter settling time and skips the copy, so the RAM keeps whatever a debugger loaded into it.

The timings are counted in clock cycles and set by parameters. The fixed delay stands for the roughly 2 ms overhead, and the per-word delay stands for the per-kilobyte load cost.

Top module: `boot_seq_top`

## Requirements
- R1: While `por_n` is low the block is in the reset-hold state: `busy`=1, `cpu_halt`=1, `boot_done`=0, `ram_we`=0.
- R2: In every state except running, `port_latch` is all ones, `port_od`=1 (open drain), `periph_rst`=1 and `clk_sel`=0 (0 is the internal 24 MHz oscillator). In the running state these follow `cpu_port_data`, `cpu_port_od` and `cpu_clk_sel`, and `periph_rst`=0.
- R3: A normal boot keeps `busy` high for exactly 1 + FIXED_CYC + L·WORD_CYC + 1 cycles, where L is the effective word count.
- R4: Word i is read at `nvm_addr`=i and written to `ram_addr`=i with `ram_wdata` equal to `nvm_rdata`, in ascending order. Each word takes WORD_CYC cycles, and `ram_we` is high only in the last of them.
- R5: `copy_len` and `debug_mode` are sampled in the first busy cycle. Later changes have no effect on that boot.
- R6: A `copy_len` of 0 releases the CPU right after the fixed delay and writes nothing.
- R7: A `copy_len` above 2^ADDR_W is limited to 2^ADDR_W words.
- R8: In debug mode the delay is DBG_CYC cycles, no RAM write occurs, and `busy` lasts 1 + DBG_CYC + 1 cycles.
- R9: `boot_done` is high for exactly one cycle, the last busy cycle. From the next cycle `busy`=0 and `cpu_halt`=0.
- R10: `shutdown_req` in the running state enters shutdown on the next cycle, where `busy`=0 and `cpu_halt`=1. The strobe is ignored in all other states.
- R11: In shutdown, a GPIO input held low starts a boot on the third rising edge after it is applied, not earlier.
- R12: A sleep-timer expiry in shutdown starts a boot on the next edge only if `sleep_tmr_en` was high with the accepted `shutdown_req`. Otherwise it is ignored.
- R13: GPIO lows and timer expiries outside shutdown do not restart or lengthen a boot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| gpio_in | input | GPIO_W | Raw GPIO levels used as wake sources |
| sleep_tmr_en | input | 1 | Sleep timer enabled, captured when shutdown is entered |
| sleep_tmr_expire | input | 1 | Sleep timer expiry pulse |
| shutdown_req | input | 1 | One-cycle request to enter shutdown |
| debug_mode | input | 1 | Debug start-up: short delay, no copy |
| copy_len | input | ADDR_W+1 | Number of words to load |
| nvm_addr | output | ADDR_W | NVM read address |
| nvm_rdata | input | DATA_W | NVM read data for `nvm_addr` |
| ram_we | output | 1 | Code RAM write enable |
| ram_addr | output | ADDR_W | Code RAM write address |
| ram_wdata | output | DATA_W | Code RAM write data |
| cpu_port_data | input | PORT_W | Port latch value from the CPU |
| cpu_port_od | input | 1 | Port open-drain select from the CPU |
| cpu_clk_sel | input | CLK_W | Clock selection from the CPU |
| port_latch | output | PORT_W | Port output latches |
| port_od | output | 1 | Ports in open-drain mode |
| clk_sel | output | CLK_W | System clock selection |
| cpu_halt | output | 1 | CPU held halted, program counter at zero |
| periph_rst | output | 1 | Peripherals, interrupts and timers held in reset |
| busy | output | 1 | Boot in progress |
| boot_done | output | 1 | One-cycle pulse at CPU release |

## Verification
A state machine stuck in or skipping a phase shows up as a wrong `busy` length, counted to the exact cycle. The bench sees this when the boot ends, within a few hundred cycles. A word counter or wait counter that is off shows on the next `ram_we` as a wrong address, wrong data or a wrong number of writes. A badly latched wake arm or a missing synchronizer stage shifts the cycle in which `busy` rises after a wake stimulus, so it is caught within three edges.

// File: rtl/boot_pkg.sv
package boot_pkg;

    typedef enum logic [2:0] {
        ST_SHUTDOWN    = 3'd0,
        ST_RESET_HOLD  = 3'd1,
        ST_FIXED_DELAY = 3'd2,
        ST_COPY        = 3'd3,
        ST_RELEASE     = 3'd4,
        ST_RUN         = 3'd5
    } boot_state_e;

    function automatic logic is_busy_state(boot_state_e s);
        return (s == ST_RESET_HOLD) || (s == ST_FIXED_DELAY) ||
               (s == ST_COPY) || (s == ST_RELEASE);
    endfunction

endpackage

// File: rtl/boot_wake_sync.sv
module boot_wake_sync #(
    parameter int GPIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GPIO_W-1:0] gpio_in,
    input  logic              in_shutdown,
    input  logic              arm_load,
    input  logic              arm_val,
    input  logic              tmr_expire,
    output logic              wake
);

    typedef struct packed {
        logic [GPIO_W-1:0] meta;
        logic [GPIO_W-1:0] sync;
        logic              armed;
    } wake_regs_t;

    wake_regs_t r_q, r_d;

    logic pin_low;
    logic tmr_hit;

    always_comb begin
        r_d      = r_q;
        r_d.meta = gpio_in;
        r_d.sync = r_q.meta;
        pin_low  = ~&r_q.sync;
        tmr_hit  = r_q.armed && tmr_expire;
        wake     = in_shutdown && (pin_low || tmr_hit);
        if (arm_load) begin
            r_d.armed = arm_val;
        end else if (wake) begin
            r_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{meta: '1, sync: '1, armed: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    // R12: an unarmed expiry alone never produces a wake
    p_unarmed_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.armed && &r_q.sync) |-> !wake);

endmodule

// File: rtl/boot_delay_timer.sv
module boot_delay_timer #(
    parameter int FIXED_CYC = 48,
    parameter int DBG_CYC   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic use_short,
    output logic done
);

    localparam int MAX_CYC = (FIXED_CYC > DBG_CYC) ? FIXED_CYC : DBG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] FIX_L = CNT_W'(FIXED_CYC);
    localparam logic [CNT_W-1:0] DBG_L = CNT_W'(DBG_CYC);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] limit;
    } tmr_regs_t;

    tmr_regs_t r_q, r_d;

    always_comb begin
        r_d  = r_q;
        done = r_q.active && (r_q.cnt == r_q.limit - CNT_W'(1));
        if (start) begin
            r_d.active = 1'b1;
            r_d.cnt    = '0;
            r_d.limit  = use_short ? DBG_L : FIX_L;
        end else if (done) begin
            r_d.active = 1'b0;
            r_d.cnt    = '0;
        end else if (r_q.active) begin
            r_d.cnt = r_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{active: 1'b0, cnt: '0, limit: FIX_L};
        end else begin
            r_q <= r_d;
        end
    end

    // R3 / R8: the count never runs past its window
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.active |-> (r_q.cnt < r_q.limit));

endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine #(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 8,
    parameter int WORD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W:0]   len,
    input  logic [DATA_W-1:0] nvm_rdata,
    output logic [ADDR_W-1:0] nvm_addr,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              done
);

    localparam int WC_W = $clog2(WORD_CYC + 1);
    localparam logic [WC_W-1:0] WC_LAST = WC_W'(WORD_CYC - 1);

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] idx;
        logic [ADDR_W-1:0] last;
        logic [WC_W-1:0]   wcnt;
    } copy_regs_t;

    copy_regs_t r_q, r_d;

    logic [ADDR_W:0] len_m1;

    always_comb begin
        r_d       = r_q;
        len_m1    = len - {{ADDR_W{1'b0}}, 1'b1};
        nvm_addr  = r_q.idx;
        ram_addr  = r_q.idx;
        ram_wdata = nvm_rdata;
        ram_we    = r_q.active && (r_q.wcnt == WC_LAST);
        done      = ram_we && (r_q.idx == r_q.last);
        if (start) begin
            r_d.active = 1'b1;
            r_d.idx    = '0;
            r_d.wcnt   = '0;
            r_d.last   = len_m1[ADDR_W-1:0];
        end else if (ram_we) begin
            r_d.wcnt = '0;
            if (done) begin
                r_d.active = 1'b0;
                r_d.idx    = '0;
            end else begin
                r_d.idx = r_q.idx + ADDR_W'(1);
            end
        end else if (r_q.active) begin
            r_d.wcnt = r_q.wcnt + WC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{active: 1'b0, idx: '0, last: '0, wcnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // R7: the word index stays inside the latched length
    p_idx_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.active |-> (r_q.idx <= r_q.last));

    // R4: writes advance the address by one
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !done) |=> (ram_addr == $past(ram_addr) + ADDR_W'(1)));

endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top #(
    parameter int GPIO_W    = 4,
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int PORT_W    = 8,
    parameter int CLK_W     = 2,
    parameter int FIXED_CYC = 48,
    parameter int DBG_CYC   = 16,
    parameter int WORD_CYC  = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [GPIO_W-1:0] gpio_in,
    input  logic              sleep_tmr_en,
    input  logic              sleep_tmr_expire,
    input  logic              shutdown_req,
    input  logic              debug_mode,
    input  logic [ADDR_W:0]   copy_len,
    output logic [ADDR_W-1:0] nvm_addr,
    input  logic [DATA_W-1:0] nvm_rdata,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [PORT_W-1:0] cpu_port_data,
    input  logic              cpu_port_od,
    input  logic [CLK_W-1:0]  cpu_clk_sel,
    output logic [PORT_W-1:0] port_latch,
    output logic              port_od,
    output logic [CLK_W-1:0]  clk_sel,
    output logic              cpu_halt,
    output logic              periph_rst,
    output logic              busy,
    output logic              boot_done
);
    import boot_pkg::*;

    localparam int LEN_W = ADDR_W + 1;
    localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(2 ** ADDR_W);
    localparam logic [CLK_W-1:0] CLK_INT_OSC = '0;

    typedef struct packed {
        boot_state_e      state;
        logic [LEN_W-1:0] len;
        logic             dbg;
    } top_regs_t;

    top_regs_t r_q, r_d;

    logic in_shutdown;
    logic running;
    logic wake;
    logic arm_load;
    logic tmr_start;
    logic tmr_done;
    logic copy_start;
    logic copy_done;
    logic [LEN_W-1:0] len_clamped;

    boot_wake_sync #(.GPIO_W(GPIO_W)) u_wake (
        .clk        (clk),
        .rst_n      (por_n),
        .gpio_in    (gpio_in),
        .in_shutdown(in_shutdown),
        .arm_load   (arm_load),
        .arm_val    (sleep_tmr_en),
        .tmr_expire (sleep_tmr_expire),
        .wake       (wake)
    );

    boot_delay_timer #(.FIXED_CYC(FIXED_CYC), .DBG_CYC(DBG_CYC)) u_delay (
        .clk      (clk),
        .rst_n    (por_n),
        .start    (tmr_start),
        .use_short(debug_mode),
        .done     (tmr_done)
    );

    boot_copy_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_CYC(WORD_CYC)) u_copy (
        .clk      (clk),
        .rst_n    (por_n),
        .start    (copy_start),
        .len      (r_q.len),
        .nvm_rdata(nvm_rdata),
        .nvm_addr (nvm_addr),
        .ram_we   (ram_we),
        .ram_addr (ram_addr),
        .ram_wdata(ram_wdata),
        .done     (copy_done)
    );

    always_comb begin
        r_d         = r_q;
        in_shutdown = (r_q.state == ST_SHUTDOWN);
        running     = (r_q.state == ST_RUN);
        arm_load    = running && shutdown_req;
        tmr_start   = (r_q.state == ST_RESET_HOLD);
        copy_start  = 1'b0;
        len_clamped = (copy_len > DEPTH_L) ? DEPTH_L : copy_len;

        unique case (r_q.state)
            ST_SHUTDOWN: begin
                if (wake) r_d.state = ST_RESET_HOLD;
            end
            ST_RESET_HOLD: begin
                r_d.len   = len_clamped;
                r_d.dbg   = debug_mode;
                r_d.state = ST_FIXED_DELAY;
            end
            ST_FIXED_DELAY: begin
                if (tmr_done) begin
                    if (r_q.dbg || (r_q.len == '0)) begin
                        r_d.state = ST_RELEASE;
                    end else begin
                        r_d.state  = ST_COPY;
                        copy_start = 1'b1;
                    end
                end
            end
            ST_COPY: begin
                if (copy_done) r_d.state = ST_RELEASE;
            end
            ST_RELEASE: begin
                r_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (shutdown_req) r_d.state = ST_SHUTDOWN;
            end
            default: r_d.state = ST_RESET_HOLD;
        endcase

        busy       = is_busy_state(r_q.state);
        boot_done  = (r_q.state == ST_RELEASE);
        cpu_halt   = !running;
        periph_rst = !running;
        port_latch = running ? cpu_port_data : '1;
        port_od    = running ? cpu_port_od : 1'b1;
        clk_sel    = running ? cpu_clk_sel : CLK_INT_OSC;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q <= '{state: ST_RESET_HOLD, len: '0, dbg: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    // R4: the copy engine writes only while the sequencer is copying
    p_we_in_copy_r4: assert property (@(posedge clk) disable iff (!por_n)
        ram_we |-> (r_q.state == ST_COPY));

    // R8: a debug boot never reaches the copy phase
    p_no_copy_debug_r8: assert property (@(posedge clk) disable iff (!por_n)
        (r_q.state == ST_COPY) |-> !r_q.dbg);

    // R9: release pulse is followed by the running state
    p_done_then_run_r9: assert property (@(posedge clk) disable iff (!por_n)
        boot_done |=> (!busy && !cpu_halt && !boot_done));

    // R10: shutdown strobe in run is taken on the next edge
    p_shutdown_taken_r10: assert property (@(posedge clk) disable iff (!por_n)
        (running && shutdown_req) |=> (r_q.state == ST_SHUTDOWN));

    // R13: a boot only restarts from shutdown
    p_no_restart_r13: assert property (@(posedge clk) disable iff (!por_n)
        (r_q.state != ST_SHUTDOWN) |=> (r_q.state != ST_RESET_HOLD));

    // R11 / R12: a wake in shutdown always starts a boot
    p_wake_exits_r11: assert property (@(posedge clk) disable iff (!por_n)
        (in_shutdown && wake) |=> (r_q.state == ST_RESET_HOLD));

endmodule

// File: tb/boot_seq_top_test.sv
module boot_seq_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int GPIO_W = 4;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int PORT_W = 8;
    localparam int CLK_W  = 2;
    localparam int FIXED_CYC = 48;
    localparam int DBG_CYC   = 16;
    localparam int WORD_CYC  = 4;
    localparam int DEPTH = 2 ** ADDR_W;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic [GPIO_W-1:0] gpio_in = '1;
    logic              sleep_tmr_en = 1'b0;
    logic              sleep_tmr_expire = 1'b0;
    logic              shutdown_req = 1'b0;
    logic              debug_mode = 1'b0;
    logic [ADDR_W:0]   copy_len = '0;
    logic [ADDR_W-1:0] nvm_addr;
    logic [DATA_W-1:0] nvm_rdata;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata;
    logic [PORT_W-1:0] cpu_port_data = 8'h5A;
    logic              cpu_port_od = 1'b0;
    logic [CLK_W-1:0]  cpu_clk_sel = 2'd2;
    logic [PORT_W-1:0] port_latch;
    logic              port_od;
    logic [CLK_W-1:0]  clk_sel;
    logic              cpu_halt;
    logic              periph_rst;
    logic              busy;
    logic              boot_done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    boot_seq_top #(
        .GPIO_W(GPIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W),
        .CLK_W(CLK_W), .FIXED_CYC(FIXED_CYC), .DBG_CYC(DBG_CYC), .WORD_CYC(WORD_CYC)
    ) uut (
        .clk(clk), .por_n(por_n), .gpio_in(gpio_in), .sleep_tmr_en(sleep_tmr_en),
        .sleep_tmr_expire(sleep_tmr_expire), .shutdown_req(shutdown_req),
        .debug_mode(debug_mode), .copy_len(copy_len), .nvm_addr(nvm_addr),
        .nvm_rdata(nvm_rdata), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .cpu_port_data(cpu_port_data),
        .cpu_port_od(cpu_port_od), .cpu_clk_sel(cpu_clk_sel),
        .port_latch(port_latch), .port_od(port_od), .clk_sel(clk_sel),
        .cpu_halt(cpu_halt), .periph_rst(periph_rst), .busy(busy),
        .boot_done(boot_done)
    );

    function automatic logic [DATA_W-1:0] nvm_fn(input logic [ADDR_W-1:0] a);
        return DATA_W'((a * 37 + 11) ^ (a >> 2));
    endfunction

    assign nvm_rdata = nvm_fn(nvm_addr);

    function automatic int eff_len(input int len);
        return (len > DEPTH) ? DEPTH : len;
    endfunction

    function automatic int exp_busy(input int len, input bit dbg);
        if (dbg) return 1 + DBG_CYC + 1;
        return 1 + FIXED_CYC + eff_len(len) * WORD_CYC + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check_forced(input string req);
        chk(port_latch == '1, req, int'(port_latch), 255);
        chk(port_od && periph_rst && cpu_halt, req,
            int'({port_od, periph_rst, cpu_halt}), 7);
        chk(clk_sel == '0, req, int'(clk_sel), 0);
    endtask

    // Runs one boot from its first busy cycle, tampering with inputs mid-way.
    task automatic run_boot(input int len, input bit dbg);
        int cyc = 0;
        int nwr = 0;
        int ndone = 0;
        int done_at = -1;
        bit order_ok = 1'b1;
        int exp = exp_busy(len, dbg);
        int exp_wr = dbg ? 0 : eff_len(len);
        while (busy && cyc < 5000) begin
            cyc++;
            if (ram_we) begin
                if (ram_addr != ADDR_W'(nwr) || ram_wdata != nvm_fn(ram_addr))
                    order_ok = 1'b0;
                nwr++;
            end
            if (boot_done) begin
                ndone++;
                done_at = cyc;
            end
            if (cyc == 2) gpio_in = '1;
            if (cyc == 3) begin
                copy_len = ADDR_W'($urandom_range(0, 63)) + 7'd1;  // R5 tamper
                debug_mode = ~dbg;
            end
            if (cyc == 5) begin
                gpio_in = '0;                                       // R13
                sleep_tmr_expire = 1'b1;
                shutdown_req = 1'b1;                                // R10 ignored
            end
            if (cyc == 6) begin
                gpio_in = '1;
                sleep_tmr_expire = 1'b0;
                shutdown_req = 1'b0;
            end
            tick();
        end
        chk(cyc == exp, dbg ? "R8 busy length" : "R3 busy length", cyc, exp);
        chk(nwr == exp_wr, dbg ? "R8 no writes" : (len == 0 ? "R6 write count" :
            (len > DEPTH ? "R7 clamp count" : "R4 write count")), nwr, exp_wr);
        chk(order_ok, "R4 address/data order", int'(order_ok), 1);
        chk(ndone == 1 && done_at == exp, "R9 done pulse", done_at, exp);
        chk(!busy && !cpu_halt && !periph_rst, "R9 released", int'({busy, cpu_halt}), 0);
        chk(ndone == 1, "R5 length latched", ndone, 1);
        debug_mode = 1'b0;
    endtask

    task automatic go_shutdown(input bit arm);
        sleep_tmr_en = arm;
        shutdown_req = 1'b1;
        tick();
        shutdown_req = 1'b0;
        sleep_tmr_en = ~arm;
        chk(!busy && cpu_halt, "R10 shutdown entered", int'({busy, cpu_halt}), 1);
        check_forced("R2 forced in shutdown");
    endtask

    task automatic wake_gpio(input int pin);
        gpio_in[pin] = 1'b0;
        tick();
        tick();
        chk(!busy, "R11 not before third edge", int'(busy), 0);
        tick();
        chk(busy, "R11 wake on third edge", int'(busy), 1);
    endtask

    task automatic wake_timer();
        sleep_tmr_expire = 1'b1;
        tick();
        sleep_tmr_expire = 1'b0;
        chk(busy, "R12 armed expiry wakes", int'(busy), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        copy_len = 7'd10;
        #(CLK_PERIOD * 3 + 2);
        chk(busy && cpu_halt && !boot_done && !ram_we, "R1 reset state",
            int'({busy, cpu_halt, boot_done, ram_we}), 12);
        check_forced("R2 forced in reset");
        @(posedge clk);
        #2;
        por_n = 1'b1;
        run_boot(10, 1'b0);

        // R2 pass-through while running
        cpu_port_data = 8'hC3; cpu_port_od = 1'b0; cpu_clk_sel = 2'd3;
        #1;
        chk(port_latch == 8'hC3 && !port_od && clk_sel == 2'd3, "R2 run pass-through",
            int'(port_latch), 8'hC3);
        // R13: GPIO low while running has no effect
        gpio_in = '0;
        tick(); tick(); tick(); tick();
        chk(!busy && !cpu_halt, "R13 run ignores wake", int'(busy), 0);
        gpio_in = '1;
        tick(); tick();

        // Unarmed timer expiry is ignored (R12)
        go_shutdown(1'b0);
        tick(); tick();
        sleep_tmr_expire = 1'b1;
        tick();
        sleep_tmr_expire = 1'b0;
        tick(); tick();
        chk(!busy && cpu_halt, "R12 unarmed expiry ignored", int'(busy), 0);
        copy_len = 7'd0;
        wake_gpio(2);
        run_boot(0, 1'b0);                       // R6

        // Armed timer, length above depth (R7)
        go_shutdown(1'b1);
        copy_len = 7'd100;
        wake_timer();
        run_boot(100, 1'b0);

        // Debug boot (R8)
        go_shutdown(1'b0);
        copy_len = 7'd30;
        debug_mode = 1'b1;
        wake_gpio(0);
        run_boot(30, 1'b1);

        // Exactly full depth
        go_shutdown(1'b0);
        copy_len = 7'(DEPTH);
        wake_gpio(3);
        run_boot(DEPTH, 1'b0);

        // Random boots
        for (int i = 0; i < 8; i++) begin
            int len = $urandom_range(0, 90);
            bit dbg = ($urandom_range(0, 3) == 0);
            bit arm = $urandom_range(0, 1) == 1;
            go_shutdown(arm);
            tick();
            copy_len = 7'(len);
            debug_mode = dbg;
            if (arm) wake_timer();
            else wake_gpio($urandom_range(0, GPIO_W - 1));
            run_boot(len, dbg);
            cpu_port_data = 8'($urandom);
            #1;
            chk(port_latch == cpu_port_data, "R2 random run pass-through",
                int'(port_latch), int'(cpu_port_data));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule